// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block collects 31 interrupt lines and passes them to up to four processors. Line 0 does not exist. Lines 1 to 15 are normal lines. Lines 16 to 31 are extended lines. Extended lines are not given a level of their own. They are signalled on a single normal line, chosen by a parameter and readable in the processor-status word. A processor that takes that level learns which extended line it took from its own extended-identity register.

Interrupt sources set bits in a shared pending register. A line can also be raised on one processor alone through that processor's force register, which is how one processor interrupts another. A broadcast register sends chosen lines to the force registers of every processor that has them unmasked, instead of to the shared pending register. Each processor has its own mask. For each processor the block outputs the highest-numbered deliverable line as a registered 4-bit level, and it accepts an acknowledge back from that processor. Out of reset only processor 0 runs. It starts the other processors by writing their bits to the processor-status word.

Software reaches the registers through a word-addressed port. A read returns its data one cycle after the read strobe.

Top module: `mpic_top`

## Requirements
- R1: After reset the following hold. Pending, broadcast, every mask and every force register read 0. Every level output is 0. The processor-status word (word 4) reads the extended line number in bits 19:16 and the run mask in bits 3:0, with only bit 0 set.
- R2: A line input held high in a cycle sets its bit in the shared pending register (word 1), unless the line is selected in the broadcast register. Writing word 1 loads the register. Bit 0 always reads 0.
- R3: Writing word 3 clears each shared pending bit whose data bit is 1. Bits written 0 are left unchanged.
- R4: Each processor's level output is the highest line number n in 1..15 for which (pending OR own force) AND own mask has bit n set. A value of 0 means no request. The output updates one clock after the state that causes it.
- R5: Processor i's force register is at word 32+i, and word 2 also reaches processor 0's force register. A bit set there raises that line on processor i only. It does not change the shared pending register.
- R6: When any extended line (16..31) is deliverable to a processor, that processor's request includes the designated line (parameter, default 10). A higher deliverable normal line still wins.
- R7: Suppose a processor acknowledges the designated level while an extended line is deliverable to it. Then the highest deliverable extended line is the one taken. Its number goes into bits 5:0 of that processor's identity register (word 48+i). The acknowledge clears that line's bit in the processor's force register if the bit is set, and otherwise clears the shared pending bit.
- R8: Acknowledging a normal level L clears bit L of the processor's own force register if that bit is set, and otherwise clears shared pending bit L.
- R9: A source on a line selected in the broadcast register (word 5) leaves the shared pending register unchanged. It sets that line in the force register of every processor whose mask has the line, and in no other.
- R10: Writing word 4 sets the run bits given in the data. A run bit is never cleared. A processor that is not running drives level 0.
- R11: Masks are per processor (word 16+i). Clearing a line in one mask leaves delivery to the other processors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt line inputs, active high; bit 0 unused |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| cpu_run | output | NCPU | Processor run enables |
| cpu_level | output | 4*NCPU | Request level per processor, processor i in bits 4i+3:4i |
| ack_valid | input | NCPU | Acknowledge strobe per processor |
| ack_level | input | 4*NCPU | Acknowledged level per processor |

## Verification
The bench targets the following cases, each with the fault it would expose:
- **Extended line that must lose to a higher normal line.** A design that let the extended group always win would report the designated level here.
- **Acknowledge with both a forced bit and a pending bit for the same line.** A design that cleared the wrong one would leave the line forced, or would drop the shared request.
- **Broadcast delivery.** A design that fed broadcast lines into the shared pending register, or that ignored the mask when forcing, would show a wrong pending or force word.
- **Processor that has a deliverable line but is not started.** A design that ignored the run mask would put a level on it.
- **Write of zero to the status word.** A design that let this write stop processors would lose the run bits.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  // fixed line structure: 16 normal (0 unused), 16 extended
  localparam int LINES = 32;
  localparam int NORM  = LINES / 2;
  localparam int LVL_W = $clog2(NORM);
  localparam int ID_W  = $clog2(LINES) + 1;

  // register word indices
  localparam int WA_PEND    = 1;
  localparam int WA_FORCE   = 2;
  localparam int WA_CLR     = 3;
  localparam int WA_MPSTAT  = 4;
  localparam int WA_BCAST   = 5;
  localparam int WA_MASK0   = 16;
  localparam int WA_FORCE0  = 32;
  localparam int WA_EXTACK0 = 48;

  localparam int EXT_FIELD_LSB = 16;
endpackage

// File: rtl/mpic_prio_enc.sv
module mpic_prio_enc #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  // highest set bit wins; 0 when nothing is set
  always_comb begin
    idx = '0;
    for (int k = 0; k < W; k++) begin
      if (vec[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/mpic_lane.sv
module mpic_lane
  import mpic_pkg::*;
#(
  parameter int EXT_LINE = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             running,
  input  logic [LINES-1:0] pending,
  input  logic [LINES-1:0] bcast_hit,
  input  logic             mask_we,
  input  logic             force_we,
  input  logic [LINES-1:0] wdata,
  input  logic             ack_valid,
  input  logic [LVL_W-1:0] ack_level,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] force_q,
  output logic [ID_W-1:0]  extack_q,
  output logic [LVL_W-1:0] level_q,
  output logic [LINES-1:0] pend_clr
);
  localparam logic [LINES-1:0] NO_ZERO = ~LINES'(1);

  logic [LINES-1:0] eff;
  logic [NORM-1:0]  ext_vec;
  logic [NORM-1:0]  norm_vec;
  logic             ext_any;
  logic [LVL_W-1:0] ext_idx;
  logic [LVL_W-1:0] norm_idx;
  logic             ack_go;
  logic             ack_ext;
  logic [ID_W-1:0]  ack_tgt;
  logic [LINES-1:0] tgt_hot;
  logic             frc_hit;

  assign eff     = (pending | force_q) & mask_q;
  assign ext_vec = eff[LINES-1:NORM];
  assign ext_any = |ext_vec;

  always_comb begin
    norm_vec           = eff[NORM-1:0];
    norm_vec[0]        = 1'b0;
    norm_vec[EXT_LINE] = norm_vec[EXT_LINE] | ext_any;
  end

  mpic_prio_enc #(.W(NORM), .IW(LVL_W)) u_ext_enc  (.vec(ext_vec),  .idx(ext_idx));
  mpic_prio_enc #(.W(NORM), .IW(LVL_W)) u_norm_enc (.vec(norm_vec), .idx(norm_idx));

  // acknowledge resolution
  assign ack_go  = ack_valid && (ack_level != '0);
  assign ack_ext = ack_go && (ack_level == LVL_W'(EXT_LINE)) && ext_any;
  assign ack_tgt = ack_ext ? (ID_W'(NORM) + ID_W'(ext_idx)) : ID_W'(ack_level);
  assign tgt_hot = LINES'(1) << ack_tgt;
  assign frc_hit = ack_go && ((force_q & tgt_hot) != '0);
  assign pend_clr = (ack_go && !frc_hit) ? tgt_hot : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      force_q  <= '0;
      extack_q <= '0;
      level_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wdata & NO_ZERO;
      if (force_we) force_q <= wdata & NO_ZERO;
      else          force_q <= (force_q & ~(frc_hit ? tgt_hot : '0)) | (bcast_hit & mask_q);
      if (ack_ext) extack_q <= ack_tgt;
      level_q <= running ? norm_idx : '0;
    end
  end

  AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !running |=> level_q == '0); // R10
  AST_EXT_SIGNALLED: assert property (@(posedge clk) disable iff (rst)
    (running && ext_any) |=> level_q >= LVL_W'(EXT_LINE)); // R6
  AST_EXTACK_RANGE: assert property (@(posedge clk) disable iff (rst)
    (extack_q == '0) || (extack_q[ID_W-1:LVL_W] == 2'b01)); // R7
  AST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (rst)
    level_q != '0 |-> $past(mask_q) != '0); // R4
endmodule

// File: rtl/mpic_top.sv
module mpic_top
  import mpic_pkg::*;
#(
  parameter int NCPU     = 4,
  parameter int EXT_LINE = 10,
  parameter int ADDR_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LINES-1:0]      irq_in,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [LINES-1:0]      wdata,
  output logic [LINES-1:0]      rdata,
  output logic [NCPU-1:0]       cpu_run,
  output logic [NCPU*LVL_W-1:0] cpu_level,
  input  logic [NCPU-1:0]       ack_valid,
  input  logic [NCPU*LVL_W-1:0] ack_level
);
  localparam logic [LINES-1:0]  NO_ZERO  = ~LINES'(1);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(WA_PEND);
  localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(WA_FORCE);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(WA_CLR);
  localparam logic [ADDR_W-1:0] A_MPSTAT = ADDR_W'(WA_MPSTAT);
  localparam logic [ADDR_W-1:0] A_BCAST  = ADDR_W'(WA_BCAST);

  logic [LINES-1:0] pend_q, bcast_q, bcast_hit, ack_clr, rd_mux;
  logic [NCPU-1:0]  run_q;

  logic [LINES-1:0] lane_mask  [NCPU];
  logic [LINES-1:0] lane_force [NCPU];
  logic [LINES-1:0] lane_pclr  [NCPU];
  logic [ID_W-1:0]  lane_extack[NCPU];
  logic [LVL_W-1:0] lane_level [NCPU];

  assign bcast_hit = irq_in & bcast_q & NO_ZERO;
  assign cpu_run   = run_q;

  generate
    for (genvar i = 0; i < NCPU; i++) begin : g_lane
      logic mask_we_i, force_we_i;
      assign mask_we_i  = wr_en && (addr == ADDR_W'(WA_MASK0 + i));
      assign force_we_i = wr_en && ((addr == ADDR_W'(WA_FORCE0 + i)) || ((i == 0) && (addr == A_FORCE)));
      mpic_lane #(.EXT_LINE(EXT_LINE)) u_lane (
        .clk(clk), .rst(rst), .running(run_q[i]),
        .pending(pend_q), .bcast_hit(bcast_hit),
        .mask_we(mask_we_i), .force_we(force_we_i), .wdata(wdata),
        .ack_valid(ack_valid[i]), .ack_level(ack_level[i*LVL_W +: LVL_W]),
        .mask_q(lane_mask[i]), .force_q(lane_force[i]), .extack_q(lane_extack[i]),
        .level_q(lane_level[i]), .pend_clr(lane_pclr[i])
      );
      assign cpu_level[i*LVL_W +: LVL_W] = lane_level[i];
    end
  endgenerate

  always_comb begin
    ack_clr = '0;
    for (int i = 0; i < NCPU; i++) ack_clr = ack_clr | lane_pclr[i];
  end

  // shared state: clears first, new sources last
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      bcast_q <= '0;
      run_q   <= NCPU'(1);
    end else begin
      pend_q <= (((wr_en && addr == A_PEND) ? wdata : pend_q)
                 & ~((wr_en && addr == A_CLR) ? wdata : '0)
                 & ~ack_clr
                 | (irq_in & ~bcast_q)) & NO_ZERO;
      if (wr_en && addr == A_BCAST)  bcast_q <= wdata & NO_ZERO;
      if (wr_en && addr == A_MPSTAT) run_q   <= run_q | wdata[NCPU-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_PEND:   rd_mux = pend_q;
      A_FORCE:  rd_mux = lane_force[0];
      A_BCAST:  rd_mux = bcast_q;
      A_MPSTAT: begin
        rd_mux[EXT_FIELD_LSB +: 4] = 4'(EXT_LINE);
        rd_mux[NCPU-1:0]           = run_q;
      end
      default:  rd_mux = '0;
    endcase
    for (int i = 0; i < NCPU; i++) begin
      if (addr == ADDR_W'(WA_MASK0 + i))   rd_mux = lane_mask[i];
      if (addr == ADDR_W'(WA_FORCE0 + i))  rd_mux = lane_force[i];
      if (addr == ADDR_W'(WA_EXTACK0 + i)) rd_mux = LINES'(lane_extack[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CLR) |=> ((pend_q & $past(wdata) & ~$past(irq_in)) == '0)); // R3
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (run_q != $past(run_q)) |-> ((run_q & $past(run_q)) == $past(run_q))); // R10
  AST_BCAST_NOT_PENDING: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_PEND) |=> ((pend_q & ~$past(pend_q) & $past(bcast_q)) == '0)); // R9
  AST_LINE0_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !pend_q[0]); // R2
endmodule

// File: tb/tb_mpic_top.sv
module tb_mpic_top;
  localparam int CLK_P  = 10;
  localparam int NCPU   = 4;
  localparam int ADDR_W = 8;

  logic              clk = 0;
  logic              rst = 1;
  logic [31:0]       irq_in = '0;
  logic              wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCPU-1:0]   cpu_run;
  logic [4*NCPU-1:0] cpu_level;
  logic [NCPU-1:0]   ack_valid = '0;
  logic [4*NCPU-1:0] ack_level = '0;

  mpic_top #(.NCPU(NCPU), .EXT_LINE(10), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cpu_run(cpu_run),
    .cpu_level(cpu_level), .ack_valid(ack_valid), .ack_level(ack_level)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int          due;
    bit          is_lvl;
    int          cpu;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  item_t it;
  int cyc = 0;
  int nvec = 0;
  int nbad = 0;
  logic [31:0] act;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare expected items due in this cycle
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      it = exp_q.pop_front();
      act = it.is_lvl ? 32'(cpu_level[it.cpu*4 +: 4]) : rdata;
      nvec++;
      if (act !== it.exp) begin
        nbad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; addr = ADDR_W'(a); wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t x;
    @(posedge clk); #1;
    rd_en = 1; addr = ADDR_W'(a);
    x.due = cyc + 1; x.is_lvl = 0; x.cpu = 0; x.exp = e; x.tag = tag;
    exp_q.push_back(x);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic lvl(input int c, input logic [3:0] e, input string tag);
    item_t x;
    @(posedge clk); #1;
    x.due = cyc; x.is_lvl = 1; x.cpu = c; x.exp = 32'(e); x.tag = tag;
    exp_q.push_back(x);
  endtask

  task automatic pulse(input logic [31:0] v);
    @(posedge clk); #1;
    irq_in = v;
    @(posedge clk); #1;
    irq_in = '0;
  endtask

  task automatic ack(input int c, input logic [3:0] l);
    @(posedge clk); #1;
    ack_valid[c] = 1'b1; ack_level[c*4 +: 4] = l;
    @(posedge clk); #1;
    ack_valid = '0; ack_level = '0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    rd(4, 32'h000A_0001, "R1 status word");
    rd(1, 32'h0, "R1 pending");
    rd(16 + 1, 32'h0, "R1 mask1");
    lvl(0, 4'd0, "R1 level0");
    // R2 source sets pending
    pulse(32'h0000_0021);
    rd(1, 32'h0000_0020, "R2 pending line 5, line 0 ignored");
    lvl(0, 4'd0, "R4 masked line gives no level");
    // R4 / R10 delivery on running and stopped processor
    wr(16, 32'h20);
    wr(17, 32'h20);
    lvl(0, 4'd5, "R4 level0 line 5");
    lvl(1, 4'd0, "R10 stopped cpu1 silent");
    pulse(32'h08);
    wr(16, 32'h28);
    lvl(0, 4'd5, "R4 highest line wins");
    // R3 clear
    wr(3, 32'h20);
    rd(1, 32'h08, "R3 clear bit 5");
    lvl(0, 4'd3, "R3 level drops to 3");
    // R8 ack clears pending
    ack(0, 4'd3);
    rd(1, 32'h0, "R8 ack cleared pending");
    lvl(0, 4'd0, "R8 level idle");
    // R10 start processors
    wr(4, 32'h0E);
    rd(4, 32'h000A_000F, "R10 all running");
    wr(4, 32'h0);
    rd(4, 32'h000A_000F, "R10 run bits sticky");
    // R5 per-cpu force
    wr(32 + 2, 32'h80);
    wr(16 + 2, 32'h80);
    wr(16 + 1, 32'h80);
    lvl(2, 4'd7, "R5 force on cpu2");
    lvl(1, 4'd0, "R5 cpu1 not raised");
    rd(1, 32'h0, "R5 pending untouched");
    ack(2, 4'd7);
    lvl(2, 4'd0, "R8 force ack level");
    rd(32 + 2, 32'h0, "R8 force bit cleared");
    // R6 / R7 extended lines on cpu1
    wr(16 + 1, 32'h0014_1004);
    pulse(32'h0014_0004);
    lvl(1, 4'd10, "R6 extended signalled on line 10");
    ack(1, 4'd10);
    rd(48 + 1, 32'd20, "R7 identity 20");
    rd(1, 32'h0004_0004, "R7 pending 20 cleared");
    lvl(1, 4'd10, "R6 line 18 still signalled");
    pulse(32'h1000);
    lvl(1, 4'd12, "R6 higher normal line wins");
    ack(1, 4'd12);
    wr(32 + 1, 32'h0004_0000);
    lvl(1, 4'd10, "R6 back to extended");
    ack(1, 4'd10);
    rd(48 + 1, 32'd18, "R7 identity 18");
    rd(32 + 1, 32'h0, "R7 force bit cleared first");
    rd(1, 32'h0004_0004, "R7 pending 18 kept");
    // R9 broadcast
    wr(3, 32'hFFFF_FFFF);
    wr(5, 32'h200);
    wr(16, 32'h200);
    wr(16 + 3, 32'h200);
    pulse(32'h200);
    rd(1, 32'h0, "R9 pending untouched");
    rd(2, 32'h200, "R9 cpu0 forced via word 2");
    rd(32 + 3, 32'h200, "R9 cpu3 forced");
    rd(32 + 2, 32'h0, "R9 cpu2 masked not forced");
    lvl(0, 4'd9, "R9 level0");
    lvl(3, 4'd9, "R9 level3");
    lvl(1, 4'd0, "R9 level1 none");
    // R11 independent masks
    wr(16, 32'h0);
    lvl(0, 4'd0, "R11 cpu0 masked off");
    lvl(3, 4'd9, "R11 cpu3 unaffected");
    repeat (3) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      nbad++;
      $display("FAIL queue: actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule